// File: doc/BRIEF.md
# Per-Phase Overcurrent Threshold Register with Stack Division

This block holds the 16-bit output overcurrent threshold command word for one phase of a multi-phase power stage. A management bus front end hands it decoded word writes and reads. Each transfer carries a phase selector byte, and the block returns an acknowledge or a negative acknowledge one cycle later. A stack count input gives the number of phases sharing the rail, and that count decides which upper mantissa bits software may change. A write that would alter a protected bit is refused and raises two sticky error flags.

The stored mantissa reads back exactly as written. The level actually applied to the fault comparator is snapped to the nearest supported ampere step. A broadcast write (selector FFh) to a three-phase stack is taken as a total rail limit, and the block divides it into a per-phase step through a second step table. A broadcast read is answered only by the primary device, which returns the applied level multiplied by the stack count. A comparator raises a sticky fault when a valid valley current sample reaches the applied level.

Top module: `oc_limit_reg`

## Requirements
- R1: Every read returns `exp_i` in bits 15:11 and zero in bits 10:8.
- R2: A per-phase read (selector other than FFh) returns bits 7:0 of the stored mantissa exactly as last accepted. Bits 5:0 of that mantissa are writable at every stack count.
- R3: `thr_amp_o` maps the stored mantissa m to a level: m<11→10, 11–13→12, 14–16→15, 17–19→19, 20–22→21, 23–25→24, 26–28→28, 29–30→30, 31–33→32, 34–36→35, 37–39→39, m≥40→40.
- R4: Bit 6 may change only when `stack_cnt_i` > 1, and bit 7 only when `stack_cnt_i` > 2.
- R5: Write responses come one cycle after `wr_en_i`. If a write would change a protected bit, it gets `nack_o`, the value is discarded, and both `cml_o` and `ivd_o` are set. A protected bit here is bits 15:11 differing from `exp_i`, any of bits 10:8 set, or a gated bit per R4. Any other write gets `ack_o` and is stored. The two responses are never asserted together.
- R6: `cml_o` and `ivd_o` stay set until a `clr_faults_i` pulse. A new error in the same cycle as the pulse wins.
- R7: A broadcast write (selector FFh) with `stack_cnt_i`=3 stores a per-phase level taken from bits 7:0 as a total: t<33→10, 33–40→12, 41–50→15, 51–59→19, 60–67→21, 68–77→24, 78–86→28, 87–92→30, 93–100→32, 101–110→35, 111–118→39, t≥119→40. At other stack counts a broadcast write behaves like a per-phase write.
- R8: A broadcast read on the primary device returns `thr_amp_o` × stack count in bits 7:0, with a stack count of 0 taken as 1. On a non-primary device it produces no `rd_valid_o`, no `ack_o` and no `nack_o`.
- R9: `oc_fault_o` sets one cycle after a sample with `valley_vld_i` high and `valley_i` ≥ `thr_amp_o`. It holds until `oc_clr_i`, and a new trip in the same cycle as `oc_clr_i` wins.
- R10: Reset loads the mantissa with `dflt_mant_i` in bits 5:0 and zeros in bits 7:6, and clears all flags and responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stack_cnt_i | input | 2 | Number of phases on the rail |
| is_primary_i | input | 1 | This device answers broadcast reads |
| exp_i | input | 5 | Exponent field, set internally |
| dflt_mant_i | input | 6 | Mantissa loaded at reset |
| wr_en_i | input | 1 | Decoded word write strobe |
| rd_en_i | input | 1 | Decoded word read strobe |
| phase_i | input | 8 | Phase selector, FFh is broadcast |
| wdata_i | input | 16 | Write data word |
| ack_o | output | 1 | Transfer accepted |
| nack_o | output | 1 | Write refused |
| rd_valid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Read data word, zero when not valid |
| clr_faults_i | input | 1 | Clears the sticky communication flags |
| cml_o | output | 1 | Summary communication error flag |
| ivd_o | output | 1 | Invalid data flag |
| valley_vld_i | input | 1 | Valley current sample valid |
| valley_i | input | 8 | Sensed valley current |
| oc_clr_i | input | 1 | Clears the overcurrent fault |
| oc_fault_o | output | 1 | Overcurrent fault, sticky |
| thr_amp_o | output | 6 | Applied threshold level |

## Verification
The assertions assume that the front end never raises `wr_en_i` and `rd_en_i` in the same cycle. They also assume that `stack_cnt_i` and `exp_i` stay stable across a transfer and its response cycle. The bench drives one transfer at a time on the falling edge and changes the stack count or exponent only between transfers. It samples every response one full cycle after the strobe, so the assumptions always hold during checked windows.

// File: rtl/oc_limit_pkg.sv
package oc_limit_pkg;
  localparam int LVL_W  = 6;
  localparam int N_STEP = 11;

  typedef enum logic [1:0] {RSP_NONE, RSP_ACK, RSP_NACK} rsp_e;

  localparam logic [LVL_W-1:0] LVL_TBL [N_STEP+1] = '{
    6'd10, 6'd12, 6'd15, 6'd19, 6'd21, 6'd24,
    6'd28, 6'd30, 6'd32, 6'd35, 6'd39, 6'd40};

  localparam logic [7:0] PH_BND [N_STEP] = '{
    8'd11, 8'd14, 8'd17, 8'd20, 8'd23, 8'd26,
    8'd29, 8'd31, 8'd34, 8'd37, 8'd40};

  localparam logic [7:0] ST_BND [N_STEP] = '{
    8'd33, 8'd41, 8'd51, 8'd60, 8'd68, 8'd78,
    8'd87, 8'd93, 8'd101, 8'd111, 8'd119};

  function automatic logic [LVL_W-1:0] quant(input logic [15:0] v, input logic stk);
    logic [LVL_W-1:0] r;
    r = LVL_TBL[0];
    for (int i = 0; i < N_STEP; i++) begin
      if (v >= {8'h00, (stk ? ST_BND[i] : PH_BND[i])}) r = LVL_TBL[i+1];
    end
    return r;
  endfunction
endpackage

// File: rtl/oc_quant.sv
module oc_quant #(
  parameter int IN_W      = 8,
  parameter bit STACK_TBL = 1'b0
) (
  input  logic [IN_W-1:0]                val_i,
  output logic [oc_limit_pkg::LVL_W-1:0] lvl_o
);
  logic [15:0] val_ext;
  assign val_ext = 16'(val_i);

  generate
    if (STACK_TBL) begin : g_stack
      assign lvl_o = oc_limit_pkg::quant(val_ext, 1'b1);
    end else begin : g_phase
      assign lvl_o = oc_limit_pkg::quant(val_ext, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/oc_wr_check.sv
module oc_wr_check #(
  parameter int REG_W     = 16,
  parameter int EXP_W     = 5,
  parameter int MANT_W    = 8,
  parameter int STK_W     = 2,
  parameter int STACK_DIV = 3
) (
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [MANT_W-1:0] cur_mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [STK_W-1:0]  stk_i,
  input  logic              bcast_i,
  output logic              legal_o,
  output logic [MANT_W-1:0] new_mant_o
);
  import oc_limit_pkg::*;
  localparam int RSV_W = REG_W - EXP_W - MANT_W;
  localparam int GATE0 = MANT_W - 2;

  logic [MANT_W-1:0] ro_mask;
  logic [LVL_W-1:0]  div_lvl;
  logic              exp_chg, rsv_chg, gate_chg;

  // upper two mantissa bits open one by one as the stack grows
  for (genvar b = 0; b < MANT_W; b++) begin : g_mask
    if (b < GATE0) begin : g_open
      assign ro_mask[b] = 1'b0;
    end else begin : g_gate
      assign ro_mask[b] = (32'(stk_i) <= (b - GATE0 + 1));
    end
  end

  assign exp_chg  = wdata_i[REG_W-1 -: EXP_W] != exp_i;
  assign rsv_chg  = |wdata_i[MANT_W +: RSV_W];
  assign gate_chg = |((wdata_i[MANT_W-1:0] ^ cur_mant_i) & ro_mask);
  assign legal_o  = !(exp_chg || rsv_chg || gate_chg);

  oc_quant #(.IN_W(MANT_W), .STACK_TBL(1'b1)) u_q_stack (
    .val_i (wdata_i[MANT_W-1:0]),
    .lvl_o (div_lvl)
  );

  assign new_mant_o = (bcast_i && (32'(stk_i) == STACK_DIV)) ? MANT_W'(div_lvl)
                                                              : wdata_i[MANT_W-1:0];
endmodule

// File: rtl/oc_rd_mux.sv
module oc_rd_mux #(
  parameter int REG_W  = 16,
  parameter int EXP_W  = 5,
  parameter int MANT_W = 8,
  parameter int STK_W  = 2
) (
  input  logic [EXP_W-1:0]               exp_i,
  input  logic [MANT_W-1:0]              mant_i,
  input  logic [oc_limit_pkg::LVL_W-1:0] lvl_i,
  input  logic [STK_W-1:0]               stk_i,
  input  logic                           bcast_i,
  output logic [REG_W-1:0]               word_o
);
  localparam int RSV_W = REG_W - EXP_W - MANT_W;
  logic [MANT_W-1:0] prod;

  assign prod   = MANT_W'(lvl_i) * MANT_W'(stk_i);
  assign word_o = {exp_i, {RSV_W{1'b0}}, (bcast_i ? prod : mant_i)};
endmodule

// File: rtl/oc_fault_cmp.sv
module oc_fault_cmp #(
  parameter int CUR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           vld_i,
  input  logic [CUR_W-1:0]               cur_i,
  input  logic [oc_limit_pkg::LVL_W-1:0] thr_i,
  input  logic                           clr_i,
  output logic                           fault_o
);
  logic trip;
  assign trip = vld_i && (cur_i >= CUR_W'(thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fault_o <= 1'b0;
    else if (trip)  fault_o <= 1'b1;
    else if (clr_i) fault_o <= 1'b0;
  end
endmodule

// File: rtl/oc_limit_reg.sv
module oc_limit_reg #(
  parameter int         REG_W     = 16,
  parameter int         EXP_W     = 5,
  parameter int         MANT_W    = 8,
  parameter int         DEF_W     = 6,
  parameter int         PH_W      = 8,
  parameter int         CUR_W     = 8,
  parameter int         STK_W     = 2,
  parameter int         STACK_DIV = 3,
  parameter logic [7:0] BCAST_SEL = 8'hFF
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [STK_W-1:0]               stack_cnt_i,
  input  logic                           is_primary_i,
  input  logic [EXP_W-1:0]               exp_i,
  input  logic [DEF_W-1:0]               dflt_mant_i,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [PH_W-1:0]                phase_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic                           ack_o,
  output logic                           nack_o,
  output logic                           rd_valid_o,
  output logic [REG_W-1:0]               rdata_o,
  input  logic                           clr_faults_i,
  output logic                           cml_o,
  output logic                           ivd_o,
  input  logic                           valley_vld_i,
  input  logic [CUR_W-1:0]               valley_i,
  input  logic                           oc_clr_i,
  output logic                           oc_fault_o,
  output logic [oc_limit_pkg::LVL_W-1:0] thr_amp_o
);
  import oc_limit_pkg::*;

  logic [MANT_W-1:0] mant_q, new_mant;
  logic [STK_W-1:0]  stk_eff;
  logic              bcast, legal;
  logic [REG_W-1:0]  rd_word;
  rsp_e              rsp_q;
  logic              rd_vld_q;
  logic [REG_W-1:0]  rdata_q;
  logic              cml_q, ivd_q;

  assign bcast   = phase_i == PH_W'(BCAST_SEL);
  assign stk_eff = (stack_cnt_i == '0) ? STK_W'(1) : stack_cnt_i;

  oc_wr_check #(
    .REG_W(REG_W), .EXP_W(EXP_W), .MANT_W(MANT_W),
    .STK_W(STK_W), .STACK_DIV(STACK_DIV)
  ) u_wr_check (
    .wdata_i    (wdata_i),
    .cur_mant_i (mant_q),
    .exp_i      (exp_i),
    .stk_i      (stk_eff),
    .bcast_i    (bcast),
    .legal_o    (legal),
    .new_mant_o (new_mant)
  );

  oc_quant #(.IN_W(MANT_W), .STACK_TBL(1'b0)) u_q_phase (
    .val_i (mant_q),
    .lvl_o (thr_amp_o)
  );

  oc_rd_mux #(
    .REG_W(REG_W), .EXP_W(EXP_W), .MANT_W(MANT_W), .STK_W(STK_W)
  ) u_rd_mux (
    .exp_i   (exp_i),
    .mant_i  (mant_q),
    .lvl_i   (thr_amp_o),
    .stk_i   (stk_eff),
    .bcast_i (bcast),
    .word_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_q   <= MANT_W'(dflt_mant_i);
      rsp_q    <= RSP_NONE;
      rd_vld_q <= 1'b0;
      rdata_q  <= '0;
      cml_q    <= 1'b0;
      ivd_q    <= 1'b0;
    end else begin
      rsp_q    <= RSP_NONE;
      rd_vld_q <= 1'b0;
      rdata_q  <= '0;
      if (clr_faults_i) begin
        cml_q <= 1'b0;
        ivd_q <= 1'b0;
      end
      if (wr_en_i) begin
        if (legal) begin
          mant_q <= new_mant;
          rsp_q  <= RSP_ACK;
        end else begin
          rsp_q <= RSP_NACK;
          cml_q <= 1'b1;
          ivd_q <= 1'b1;
        end
      end else if (rd_en_i && (!bcast || is_primary_i)) begin
        rsp_q    <= RSP_ACK;
        rd_vld_q <= 1'b1;
        rdata_q  <= rd_word;
      end
    end
  end

  oc_fault_cmp #(.CUR_W(CUR_W)) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (valley_vld_i),
    .cur_i   (valley_i),
    .thr_i   (thr_amp_o),
    .clr_i   (oc_clr_i),
    .fault_o (oc_fault_o)
  );

  assign ack_o      = rsp_q == RSP_ACK;
  assign nack_o     = rsp_q == RSP_NACK;
  assign rd_valid_o = rd_vld_q;
  assign rdata_o    = rdata_q;
  assign cml_o      = cml_q;
  assign ivd_o      = ivd_q;
endmodule

// File: rtl/oc_limit_chk.sv
module oc_limit_chk #(
  parameter int REG_W = 16,
  parameter int PH_W  = 8,
  parameter int CUR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             is_primary_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [PH_W-1:0]  phase_i,
  input logic             ack_o,
  input logic             nack_o,
  input logic             rd_valid_o,
  input logic [REG_W-1:0] rdata_o,
  input logic             clr_faults_i,
  input logic             cml_o,
  input logic             ivd_o,
  input logic             valley_vld_i,
  input logic [CUR_W-1:0] valley_i,
  input logic             oc_clr_i,
  input logic             oc_fault_o,
  input logic [5:0]       thr_amp_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rdata_o[10:8] == 3'b000); // R1
  AST_THR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_amp_o >= 6'd10 && thr_amp_o <= 6'd40); // R3
  AST_RSP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && nack_o)); // R5
  AST_NACK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> (cml_o && ivd_o)); // R5
  AST_NACK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> $stable(thr_amp_o)); // R5
  AST_CML_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cml_o && !clr_faults_i) |=> cml_o); // R6
  AST_IVD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivd_o && !clr_faults_i) |=> ivd_o); // R6
  AST_NONPRI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && phase_i == 8'hFF && !is_primary_i)
      |=> (!rd_valid_o && !ack_o && !nack_o)); // R8
  AST_FAULT_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valley_vld_i && valley_i >= CUR_W'(thr_amp_o)) |=> oc_fault_o); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_fault_o && !oc_clr_i) |=> oc_fault_o); // R9
endmodule

bind oc_limit_reg oc_limit_chk #(.REG_W(REG_W), .PH_W(PH_W), .CUR_W(CUR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .is_primary_i (is_primary_i),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .phase_i      (phase_i),
  .ack_o        (ack_o),
  .nack_o       (nack_o),
  .rd_valid_o   (rd_valid_o),
  .rdata_o      (rdata_o),
  .clr_faults_i (clr_faults_i),
  .cml_o        (cml_o),
  .ivd_o        (ivd_o),
  .valley_vld_i (valley_vld_i),
  .valley_i     (valley_i),
  .oc_clr_i     (oc_clr_i),
  .oc_fault_o   (oc_fault_o),
  .thr_amp_o    (thr_amp_o)
);

// File: tb/sim_oc_limit_reg.sv
module sim_oc_limit_reg;
  localparam logic [4:0] EXPV = 5'h1F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  stack_cnt_i = 2'd1;
  logic        is_primary_i = 1'b1;
  logic [4:0]  exp_i = EXPV;
  logic [5:0]  dflt_mant_i = 6'd35;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  phase_i = 8'h00;
  logic [15:0] wdata_i = '0;
  logic        ack_o, nack_o, rd_valid_o;
  logic [15:0] rdata_o;
  logic        clr_faults_i = 1'b0;
  logic        cml_o, ivd_o;
  logic        valley_vld_i = 1'b0;
  logic [7:0]  valley_i = '0;
  logic        oc_clr_i = 1'b0;
  logic        oc_fault_o;
  logic [5:0]  thr_amp_o;

  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  oc_limit_reg u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [7:0] m);
    return {EXPV, 3'b000, m};
  endfunction

  task automatic wr(input logic [7:0] ph, input logic [15:0] d, input bit ok, input string req);
    @(negedge clk_i);
    wr_en_i = 1'b1; phase_i = ph; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check({req, " ack"}, ack_o, ok);
    check({req, " nack"}, nack_o, !ok);
  endtask

  task automatic rd(input logic [7:0] ph, input bit vld, input logic [15:0] d, input string req);
    @(negedge clk_i);
    rd_en_i = 1'b1; phase_i = ph;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check({req, " rd_valid"}, rd_valid_o, vld);
    check({req, " ack"}, ack_o, vld);
    check({req, " rdata"}, rdata_o, d);
  endtask

  task automatic clr_flags();
    @(negedge clk_i); clr_faults_i = 1'b1;
    @(negedge clk_i); clr_faults_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 cml", cml_o, 0);
    check("R10 ivd", ivd_o, 0);
    check("R10 fault", oc_fault_o, 0);
    check("R10 thr", thr_amp_o, 35);
    rd(8'h00, 1, 16'hF823, "R10 R1 reset read");
  endtask

  task automatic t_quant();
    logic [7:0] m [19] = '{5, 10, 11, 13, 14, 16, 17, 20, 23, 26, 29, 30, 31, 34, 36, 37, 39, 40, 63};
    logic [5:0] e [19] = '{10, 10, 12, 12, 15, 15, 19, 21, 24, 28, 30, 30, 32, 35, 35, 39, 39, 40, 40};
    stack_cnt_i = 2'd1;
    for (int i = 0; i < 19; i++) begin
      wr(8'h00, mk(m[i]), 1, "R2 write");
      check("R3 level", thr_amp_o, e[i]);
    end
    rd(8'h00, 1, mk(8'd63), "R2 readback");
  endtask

  task automatic t_lock();
    stack_cnt_i = 2'd1;
    wr(8'h00, mk(8'h40), 0, "R4 bit6 stack1");
    check("R5 cml set", cml_o, 1);
    check("R5 ivd set", ivd_o, 1);
    check("R5 value kept", thr_amp_o, 40);
    rd(8'h00, 1, mk(8'd63), "R5 discarded");
    wr(8'h00, mk(8'd25), 1, "R6 valid write");
    check("R6 cml sticky", cml_o, 1);
    check("R6 ivd sticky", ivd_o, 1);
    clr_flags();
    check("R6 cml clear", cml_o, 0);
    check("R6 ivd clear", ivd_o, 0);
    wr(8'h00, 16'h0019, 0, "R5 exponent change");
    wr(8'h00, 16'hF919, 0, "R5 reserved set");
    check("R5 kept", thr_amp_o, 24);
    clr_flags();
    stack_cnt_i = 2'd2;
    wr(8'h00, mk(8'h45), 1, "R4 bit6 stack2");
    check("R3 level 69", thr_amp_o, 40);
    rd(8'h00, 1, mk(8'h45), "R2 R4 readback");
    wr(8'h00, mk(8'h85), 0, "R4 bit7 stack2");
    stack_cnt_i = 2'd3;
    wr(8'h00, mk(8'h85), 1, "R4 bit7 stack3");
    rd(8'h00, 1, mk(8'h85), "R4 readback");
    wr(8'h00, mk(8'h19), 1, "R4 clear upper");
    clr_flags();
    check("R6 cleared", cml_o, 0);
  endtask

  task automatic t_bcast();
    stack_cnt_i = 2'd3;
    wr(8'hFF, mk(8'd72), 1, "R7 total 72");
    check("R7 level 24", thr_amp_o, 24);
    rd(8'h00, 1, mk(8'd24), "R7 stored level");
    rd(8'hFF, 1, mk(8'd72), "R8 product 72");
    wr(8'hFF, mk(8'd32), 1, "R7 total 32");
    check("R7 level 10", thr_amp_o, 10);
    rd(8'hFF, 1, mk(8'd30), "R8 product 30");
    wr(8'hFF, mk(8'd33), 1, "R7 total 33");
    check("R7 level 12", thr_amp_o, 12);
    wr(8'hFF, mk(8'd110), 1, "R7 total 110");
    check("R7 level 35", thr_amp_o, 35);
    wr(8'hFF, mk(8'd118), 1, "R7 total 118");
    check("R7 level 39", thr_amp_o, 39);
    wr(8'hFF, mk(8'd119), 1, "R7 total 119");
    check("R7 level 40", thr_amp_o, 40);
    rd(8'hFF, 1, mk(8'd120), "R8 product 120");
    wr(8'hFF, mk(8'd35), 1, "R7 clear upper");
    stack_cnt_i = 2'd2;
    wr(8'hFF, mk(8'd20), 1, "R7 stack2 plain");
    check("R7 stack2 level", thr_amp_o, 21);
    rd(8'h00, 1, mk(8'd20), "R7 stack2 stored");
    rd(8'hFF, 1, mk(8'd42), "R8 product 42");
    is_primary_i = 1'b0;
    rd(8'hFF, 0, 16'h0000, "R8 non-primary");
    check("R8 no nack", nack_o, 0);
    rd(8'h00, 1, mk(8'd20), "R8 non-primary phase read");
    is_primary_i = 1'b1;
    stack_cnt_i = 2'd1;
    rd(8'hFF, 1, mk(8'd21), "R8 product stack1");
  endtask

  task automatic sample(input logic v, input logic [7:0] c, input logic clr, input bit exp, input string req);
    @(negedge clk_i);
    valley_vld_i = v; valley_i = c; oc_clr_i = clr;
    @(negedge clk_i);
    valley_vld_i = 1'b0; oc_clr_i = 1'b0;
    check(req, oc_fault_o, exp);
  endtask

  task automatic t_fault();
    stack_cnt_i = 2'd1;
    wr(8'h00, mk(8'd23), 1, "R9 setup");
    check("R9 thr", thr_amp_o, 24);
    sample(1, 8'd23, 0, 0, "R9 below");
    sample(1, 8'd24, 0, 1, "R9 equal trips");
    sample(1, 8'd0, 0, 1, "R9 sticky");
    sample(0, 8'd0, 1, 0, "R9 clear");
    sample(0, 8'd40, 0, 0, "R9 invalid sample");
    sample(1, 8'd200, 1, 1, "R9 trip beats clear");
    sample(0, 8'd0, 1, 0, "R9 clear again");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_quant();
    t_lock();
    t_bcast();
    t_fault();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule